// File: doc/BRIEF.md
# Pixel Format Expander with Colormap

This block turns one stored pixel word into a 32-bit ARGB value ready for the display path. A 3-bit format code picks how the word is read: as an 8-bit colormap index, as 16-bit 5-6-5 colour, as 16-bit 1-5-5-5 colour with a one-bit alpha, as 24-bit colour, or as 32-bit colour with an alpha byte. Indexed pixels are resolved through a 1024-entry colormap RAM. Direct-colour pixels are split into fields and every field is widened to 8 bits.

The colormap is loaded through a small write port that carries an index and a 32-bit entry. The index port is one bit wider than the table needs, so an out-of-range index can be presented and is refused. Pixel data moves through a single register stage: a pixel offered with its valid strobe appears on the output, with its own valid strobe, one clock later. An unused format code yields a zero pixel and raises an error flag that stays set until reset.

Top module: `pix_expand`

## Requirements
- R1: `out_valid` equals the value of `pix_valid` one clock earlier, and `out_argb` carries the result for the pixel offered in that earlier cycle.
- R2: Format code 0 (8-bit indexed) outputs the colormap entry whose index is `pix_word[7:0]`; an entry is packed as alpha 31:24, red 23:16, green 15:8, blue 7:0.
- R3: Format code 1 (5-6-5) reads blue from bits 4:0, green from 10:5 and red from 15:11; output alpha is 0xFF.
- R4: Format code 2 (1-5-5-5) reads blue from bits 4:0, green from 9:5, red from 14:10 and alpha from bit 15; an alpha bit of 1 gives 0xFF and 0 gives 0x00.
- R5: Format code 4 (24-bit) passes bits 23:0 as red/green/blue, ignores bits 31:24 and outputs alpha 0xFF.
- R6: Format code 5 (32-bit) passes the whole word through unchanged as alpha/red/green/blue.
- R7: A field narrower than 8 bits is widened by appending its own top bits below it, so an all-ones field gives 0xFF and an all-zero field gives 0x00.
- R8: A colormap write with `cm_we` high and `cm_idx` at most 1023 stores `cm_data` at that index, visible to indexed pixels offered on later cycles.
- R9: A colormap write with `cm_idx` above 1023 is refused: no entry changes, including the entry whose index equals the low ten bits.
- R10: Format codes 3, 6 and 7 produce an all-zero `out_argb` and set `fmt_err`, which stays high until reset.
- R11: While `rst` is high and in the first cycle after it, `out_valid` and `fmt_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Pixel word and format are valid |
| pix_fmt | input | 3 | Format code of the pixel |
| pix_word | input | 32 | Stored pixel word, low-aligned |
| cm_we | input | 1 | Colormap write strobe |
| cm_idx | input | 11 | Colormap write index (values above 1023 refused) |
| cm_data | input | 32 | Colormap entry to write |
| out_valid | output | 1 | Output pixel valid |
| out_argb | output | 32 | Expanded pixel, alpha 31:24, red 23:16, green 15:8, blue 7:0 |
| fmt_err | output | 1 | Sticky flag for an unused format code |

## Verification
The embedded properties watch every cycle for the one-cycle valid delay, the fixed 0xFF alpha of the alpha-less formats, the full-scale widening of a saturated red field, the zero result of unused codes and the stickiness of the error flag. Colormap content can only be judged against a shadow table: the bench loads the table, looks up indices across the formats with random words, and shows that an out-of-range write leaves its aliased entry intact. Field placement for every format is compared against bench-computed expected values under random stimulus plus directed all-ones and all-zero words.

// File: rtl/pix_expand_pkg.sv
package pix_expand_pkg;

  typedef enum logic [2:0] {
    FMT_IDX8     = 3'd0,
    FMT_RGB565   = 3'd1,
    FMT_ARGB1555 = 3'd2,
    FMT_UNUSED3  = 3'd3,
    FMT_RGB888   = 3'd4,
    FMT_ARGB8888 = 3'd5
  } pix_fmt_e;

  function automatic logic [7:0] grow5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [7:0] grow6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction

  function automatic logic [7:0] grow1(input logic v);
    return {8{v}};
  endfunction

endpackage

// File: rtl/pix_cmap_ram.sv
module pix_cmap_ram #(
  parameter int DEPTH = 1024,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/pix_direct_unpack.sv
module pix_direct_unpack
  import pix_expand_pkg::*;
(
  input  logic [2:0]  fmt,
  input  logic [31:0] word,
  output logic [31:0] argb,
  output logic        is_idx,
  output logic        is_bad
);

  always_comb begin
    argb   = '0;
    is_idx = 1'b0;
    is_bad = 1'b0;
    case (fmt)
      FMT_IDX8:     is_idx = 1'b1;
      FMT_RGB565:   argb = {8'hFF, grow5(word[15:11]), grow6(word[10:5]), grow5(word[4:0])};
      FMT_ARGB1555: argb = {grow1(word[15]), grow5(word[14:10]), grow5(word[9:5]), grow5(word[4:0])};
      FMT_RGB888:   argb = {8'hFF, word[23:0]};
      FMT_ARGB8888: argb = word;
      default:      is_bad = 1'b1;
    endcase
  end

endmodule

// File: rtl/pix_expand.sv
module pix_expand
  import pix_expand_pkg::*;
#(
  parameter int CMAP_DEPTH = 1024,
  parameter int INDEX_BITS = 8,
  localparam int CM_AW     = $clog2(CMAP_DEPTH),
  localparam int CM_PORT_W = CM_AW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pix_valid,
  input  logic [2:0]           pix_fmt,
  input  logic [31:0]          pix_word,
  input  logic                 cm_we,
  input  logic [CM_PORT_W-1:0] cm_idx,
  input  logic [31:0]          cm_data,
  output logic                 out_valid,
  output logic [31:0]          out_argb,
  output logic                 fmt_err
);

  logic [31:0] dir_argb, dir_q, ram_q;
  logic        dir_is_idx, dir_is_bad;
  logic        sel_idx_q, valid_q, err_q;
  logic        wr_ok;
  logic [CM_AW-1:0] rd_index;

  assign wr_ok    = cm_we && (cm_idx < CM_PORT_W'(CMAP_DEPTH));
  assign rd_index = CM_AW'(pix_word[INDEX_BITS-1:0]);

  pix_cmap_ram #(.DEPTH(CMAP_DEPTH), .DW(32)) cmap_i (
    .clk     (clk),
    .wr_en   (wr_ok),
    .wr_addr (cm_idx[CM_AW-1:0]),
    .wr_data (cm_data),
    .rd_addr (rd_index),
    .rd_data (ram_q)
  );

  pix_direct_unpack unpack_i (
    .fmt    (pix_fmt),
    .word   (pix_word),
    .argb   (dir_argb),
    .is_idx (dir_is_idx),
    .is_bad (dir_is_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q   <= 1'b0;
      sel_idx_q <= 1'b0;
      dir_q     <= '0;
      err_q     <= 1'b0;
    end else begin
      valid_q <= pix_valid;
      if (pix_valid) begin
        sel_idx_q <= dir_is_idx;
        dir_q     <= dir_is_bad ? 32'h0 : dir_argb;
        if (dir_is_bad) err_q <= 1'b1;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_argb  = sel_idx_q ? ram_q : dir_q;
  assign fmt_err   = err_q;

  // R1
  valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(pix_valid)));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    fmt_err |=> fmt_err);

  // R10
  bad_code_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && (pix_fmt == 3'd3 || pix_fmt > 3'd5)) |=> (out_argb == 32'h0 && fmt_err));

  // R3
  no_alpha_full_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && (pix_fmt == 3'd1 || pix_fmt == 3'd4)) |=> (out_argb[31:24] == 8'hFF));

  // R7
  red_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && pix_fmt == 3'd1 && pix_word[15:11] == 5'h1F) |=> (out_argb[23:16] == 8'hFF));

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !fmt_err));

endmodule

// File: tb/pix_expand_tb_top.sv
module pix_expand_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic        pix_valid;
  logic [2:0]  pix_fmt;
  logic [31:0] pix_word;
  logic        cm_we;
  logic [10:0] cm_idx;
  logic [31:0] cm_data;
  logic        out_valid;
  logic [31:0] out_argb;
  logic        fmt_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] shadow [1024];

  always #2.5 clk = ~clk;

  pix_expand dut_i (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_fmt(pix_fmt),
    .pix_word(pix_word), .cm_we(cm_we), .cm_idx(cm_idx), .cm_data(cm_data),
    .out_valid(out_valid), .out_argb(out_argb), .fmt_err(fmt_err)
  );

  function automatic logic [7:0] w5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [31:0] expect_pix(input logic [2:0] f, input logic [31:0] w);
    case (f)
      3'd0: return shadow[w[7:0]];
      3'd1: return {8'hFF, w5(w[15:11]), w[10:5], w[10:9], w5(w[4:0])};
      3'd2: return {{8{w[15]}}, w5(w[14:10]), w5(w[9:5]), w5(w[4:0])};
      3'd4: return {8'hFF, w[23:0]};
      3'd5: return w;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cm_write(input logic [10:0] idx, input logic [31:0] d);
    @(negedge clk);
    cm_we = 1'b1; cm_idx = idx; cm_data = d;
    if (idx < 11'd1024) shadow[idx[9:0]] = d;
    @(negedge clk);
    cm_we = 1'b0;
  endtask

  task automatic send(input string req, input logic [2:0] f, input logic [31:0] w);
    logic [31:0] e;
    @(negedge clk);
    pix_valid = 1'b1; pix_fmt = f; pix_word = w;
    e = expect_pix(f, w);
    @(negedge clk);
    pix_valid = 1'b0;
    check({req, " R1 valid"}, {31'd0, out_valid}, 32'd1);
    check(req, out_argb, e);
  endtask

  initial begin
    #(5ns * 100000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [2:0] fl [5];
    seed = 32'd12345;
    void'($urandom(seed));
    fl[0] = 3'd0; fl[1] = 3'd1; fl[2] = 3'd2; fl[3] = 3'd4; fl[4] = 3'd5;
    rst = 1'b1; pix_valid = 1'b0; pix_fmt = '0; pix_word = '0;
    cm_we = 1'b0; cm_idx = '0; cm_data = '0;
    repeat (3) @(negedge clk);
    check("R11 out_valid in reset", {31'd0, out_valid}, 32'd0);
    check("R11 fmt_err in reset", {31'd0, fmt_err}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R11 out_valid after reset", {31'd0, out_valid}, 32'd0);

    for (int i = 0; i < 1024; i++) cm_write(11'(i), $urandom());

    // directed corner words
    send("R3 565 all ones R7", 3'd1, 32'h0000FFFF);
    send("R3 565 zero R7", 3'd1, 32'h0);
    send("R4 1555 alpha set", 3'd2, 32'h0000FFFF);
    send("R4 1555 alpha clear", 3'd2, 32'h00007FFF);
    send("R5 24-bit top byte ignored", 3'd4, 32'h5A123456);
    send("R6 32-bit passthrough", 3'd5, 32'h80ABCDEF);
    send("R2 indexed top entry", 3'd0, 32'hFFFFFF00 | 32'hFF);

    // R8: rewrite then read
    cm_write(11'd37, 32'hCAFEF00D);
    send("R8 written entry read back", 3'd0, 32'h00000025);
    // R9: out-of-range write aliasing index 37 must be refused
    cm_write(11'd1061, 32'hDEADBEEF);
    send("R9 refused write leaves entry", 3'd0, 32'h00000025);
    cm_write(11'd2047, 32'h01234567);
    send("R9 refused write top index", 3'd0, 32'h000000FF);

    check("R10 no error yet", {31'd0, fmt_err}, 32'd0);

    for (int i = 0; i < 400; i++) begin
      logic [2:0] f;
      f = fl[$urandom_range(0, 4)];
      send("R2-R6 random", f, $urandom());
    end
    check("R10 still clear after valid formats", {31'd0, fmt_err}, 32'd0);

    // idle cycle: valid must drop
    @(negedge clk);
    check("R1 idle", {31'd0, out_valid}, 32'd0);

    send("R10 code 3 zero", 3'd3, 32'hFFFFFFFF);
    check("R10 flag set", {31'd0, fmt_err}, 32'd1);
    send("R10 code 6 zero", 3'd6, 32'h12345678);
    send("R10 code 7 zero", 3'd7, 32'h87654321);
    send("R10 valid after error R6", 3'd5, 32'h11223344);
    check("R10 flag sticky", {31'd0, fmt_err}, 32'd1);

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 flag cleared by reset", {31'd0, fmt_err}, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule